// File: doc/BRIEF.md
# Program Counter with Jump Selection

This block keeps the instruction address of a small accumulator-style processor and works out, once per instruction, where execution goes next. It is told which operation is being executed (a 3-bit opcode), which addressing mode came with it (2 bits), the 8-bit operand field, the contents of register B, and the Zero and Carry flags the processor has already captured. From these it either steps the counter forward by one or loads a jump target. Its registered value drives the program memory address.

A jump target can come from one of three places. It can be a direct address taken from the operand. It can be the value held in register B. It can be a relative target, formed by adding the operand to the current address as a signed byte and then adding one more. The counter changes on the falling clock edge, which is the edge opposite the one the instruction register loads on, so a freshly decoded instruction has half a cycle to settle before it moves the counter. Reset is synchronous and a clock enable freezes the counter.

Top module: `pc_jump_unit`

## Requirements
- R1: When `rst` is high at a falling clock edge, `pc` becomes 0x00 at that edge, whatever the value of `clk_en`.
- R2: When `rst` is low and `clk_en` is low at a falling edge, `pc` keeps its value.
- R3: Opcodes 000, 001, 010, 011 and 111 are not jumps: with `clk_en` high, `pc` becomes `pc + 1` modulo 256 at the falling edge, whatever the mode, so 0xFF steps to 0x00.
- R4: A taken jump in mode 01 loads `pc` with `operand`.
- R5: A taken jump in mode 10 loads `pc` with `reg_b`.
- R6: A taken jump in mode 00 loads `pc` with `pc + operand + 1` modulo 256, with `operand` read as a two's-complement byte, so 0xFF gives `pc` and 0x80 gives `pc - 127`.
- R7: Opcode 100 always jumps, opcode 101 jumps only while `flag_z` is 1, and opcode 110 jumps only while `flag_c` is 1. An untaken conditional jump increments `pc` by one.
- R8: Mode 11 with opcode 100, 101 or 110 is illegal. `illegal` is then 1 in the same cycle, combinationally, and with `clk_en` high `pc` increments by one. In every other case `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Counter advances only while high |
| opcode | input | 3 | Opcode of the executing instruction |
| mode | input | 2 | Addressing mode of the executing instruction |
| operand | input | 8 | Operand byte: direct address or signed offset |
| reg_b | input | 8 | Register B contents, used as the indirect jump target |
| flag_z | input | 1 | Captured Zero flag |
| flag_c | input | 1 | Captured Carry flag |
| pc | output | 8 | Current program counter, the program memory address |
| illegal | output | 1 | Jump opcode combined with mode 11 |

## Verification
`illegal` is combinational, so the bench reads it 1 ns after it changes the inputs, which is well before the next falling edge. `pc` passes through a single register, so each new value is due at the first falling edge after the inputs change. The bench applies inputs just after a rising edge and reads `pc` 1 ns after the following falling edge. Its model moves forward once per falling edge in exactly the same way, which keeps every expected value in line with the cycle in which the design produces it.

// File: rtl/pcj_pkg.sv
package pcj_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'b000,
        OP_STORE = 3'b001,
        OP_ADD   = 3'b010,
        OP_SUB   = 3'b011,
        OP_JMP   = 3'b100,
        OP_JMPZ  = 3'b101,
        OP_JMPC  = 3'b110,
        OP_NOP   = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        MD_REL  = 2'b00,
        MD_DIR  = 2'b01,
        MD_IND  = 2'b10,
        MD_BAD  = 2'b11
    } jmode_e;

endpackage

// File: rtl/pcj_branch_cond.sv
module pcj_branch_cond
    import pcj_pkg::*;
(
    input  logic [2:0] opcode_i,
    input  logic [1:0] mode_i,
    input  logic       flag_z_i,
    input  logic       flag_c_i,
    output logic       take_o,
    output logic       illegal_o
);

    logic is_jump;
    logic cond_ok;

    always_comb begin
        is_jump = 1'b0;
        cond_ok = 1'b0;
        unique case (opcode_i)
            OP_JMP:  begin is_jump = 1'b1; cond_ok = 1'b1;     end
            OP_JMPZ: begin is_jump = 1'b1; cond_ok = flag_z_i; end
            OP_JMPC: begin is_jump = 1'b1; cond_ok = flag_c_i; end
            default: begin is_jump = 1'b0; cond_ok = 1'b0;     end
        endcase
        illegal_o = is_jump && (mode_i == MD_BAD);
        take_o    = is_jump && cond_ok && (mode_i != MD_BAD);
    end

endmodule

// File: rtl/pcj_target_sel.sv
module pcj_target_sel
    import pcj_pkg::*;
#(
    parameter int PC_W = 8,
    parameter int OPND_W = 8
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [1:0]        mode_i,
    input  logic [OPND_W-1:0] operand_i,
    input  logic [PC_W-1:0]   reg_b_i,
    output logic [PC_W-1:0]   target_o
);

    logic [PC_W-1:0] opnd_ext;
    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] dir_tgt;

    generate
        if (OPND_W >= PC_W) begin : g_trunc
            assign opnd_ext = operand_i[PC_W-1:0];
        end else begin : g_sext
            assign opnd_ext = {{(PC_W-OPND_W){operand_i[OPND_W-1]}}, operand_i};
        end
    endgenerate

    always_comb begin
        dir_tgt = opnd_ext;
        rel_tgt = pc_i + opnd_ext + PC_W'(1);
        unique case (mode_i)
            MD_REL:  target_o = rel_tgt;
            MD_DIR:  target_o = dir_tgt;
            MD_IND:  target_o = reg_b_i;
            default: target_o = pc_i + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/pc_jump_unit.sv
module pc_jump_unit
    import pcj_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clk_en,
    input  logic [2:0]      opcode,
    input  logic [1:0]      mode,
    input  logic [PC_W-1:0] operand,
    input  logic [PC_W-1:0] reg_b,
    input  logic            flag_z,
    input  logic            flag_c,
    output logic [PC_W-1:0] pc,
    output logic            illegal
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    state_t          st_d, st_q;
    logic            take;
    logic [PC_W-1:0] target;

    pcj_branch_cond u_cond (
        .opcode_i  (opcode),
        .mode_i    (mode),
        .flag_z_i  (flag_z),
        .flag_c_i  (flag_c),
        .take_o    (take),
        .illegal_o (illegal)
    );

    pcj_target_sel #(.PC_W(PC_W), .OPND_W(PC_W)) u_tgt (
        .pc_i      (st_q.pc),
        .mode_i    (mode),
        .operand_i (operand),
        .reg_b_i   (reg_b),
        .target_o  (target)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (clk_en) begin
            st_d.pc = take ? target : st_q.pc + PC_W'(1);
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign pc = st_q.pc;

    // R1
    reset_zero_chk: assert property (@(negedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0));

    // R2
    hold_chk: assert property (@(negedge clk) disable iff (rst)
        !clk_en |=> (pc == $past(pc)));

    // R3
    step_chk: assert property (@(negedge clk) disable iff (rst)
        (clk_en && !take) |=> (pc == PC_W'($past(pc) + PC_W'(1))));

    // R4
    direct_chk: assert property (@(negedge clk) disable iff (rst)
        (clk_en && take && mode == MD_DIR) |=> (pc == $past(operand)));

    // R5
    indirect_chk: assert property (@(negedge clk) disable iff (rst)
        (clk_en && take && mode == MD_IND) |=> (pc == $past(reg_b)));

    // R6
    relative_chk: assert property (@(negedge clk) disable iff (rst)
        (clk_en && take && mode == MD_REL)
        |=> (pc == PC_W'($past(pc) + $past(operand) + PC_W'(1))));

    // R7
    cond_clear_chk: assert property (@(negedge clk) disable iff (rst)
        ((opcode == OP_JMPZ && !flag_z) || (opcode == OP_JMPC && !flag_c)) |-> !take);

    // R8
    illegal_no_take_chk: assert property (@(negedge clk) disable iff (rst)
        illegal |-> (!take && mode == MD_BAD));

endmodule

// File: tb/pc_jump_unit_tb.sv
`timescale 1ns/1ps
module pc_jump_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic [2:0] opcode = 3'b000;
    logic [1:0] mode = 2'b00;
    logic [7:0] operand = 8'h00;
    logic [7:0] reg_b = 8'h00;
    logic       flag_z = 1'b0;
    logic       flag_c = 1'b0;
    logic [7:0] pc;
    logic       illegal;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] model_pc = 8'h00;

    always #4 clk = ~clk;

    pc_jump_unit u_dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .opcode(opcode), .mode(mode),
        .operand(operand), .reg_b(reg_b), .flag_z(flag_z), .flag_c(flag_c),
        .pc(pc), .illegal(illegal)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [2:0] op, input logic [1:0] md,
                                      input logic z, input logic c);
        if (op < 3'd4 || op == 3'd7) return "R3";
        if (md == 2'd3) return "R8";
        if ((op == 3'd5 && !z) || (op == 3'd6 && !c)) return "R7";
        if (md == 2'd0) return "R6";
        if (md == 2'd1) return "R4";
        return "R5";
    endfunction

    task automatic step(input logic r, input logic en, input logic [2:0] op,
                        input logic [1:0] md, input logic [7:0] opnd,
                        input logic [7:0] b, input logic z, input logic c);
        logic is_j, taken, exp_ill;
        string tg;
        @(posedge clk);
        #1;
        rst = r; clk_en = en; opcode = op; mode = md;
        operand = opnd; reg_b = b; flag_z = z; flag_c = c;
        is_j = (op == 3'd4) || (op == 3'd5) || (op == 3'd6);
        exp_ill = is_j && (md == 2'd3);
        taken = is_j && (md != 2'd3) &&
                ((op == 3'd4) || (op == 3'd5 && z) || (op == 3'd6 && c));
        #1;
        check("R8 illegal", {7'd0, illegal}, {7'd0, exp_ill});
        if (r) model_pc = 8'h00;
        else if (en) begin
            if (!taken) model_pc = model_pc + 8'd1;
            else if (md == 2'd0) model_pc = model_pc + opnd + 8'd1;
            else if (md == 2'd1) model_pc = opnd;
            else model_pc = b;
        end
        @(negedge clk);
        #1;
        if (r) tg = "R1";
        else if (!en) tg = "R2";
        else tg = tag_for(op, md, z, c);
        check(tg, pc, model_pc);
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=%02h expected=%02h", 8'hFF, 8'h00);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1 reset with enable low and high
        step(1'b1, 1'b0, 3'd0, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);
        step(1'b1, 1'b1, 3'd4, 2'd1, 8'h33, 8'h00, 1'b0, 1'b0);
        // R3 wrap from FF to 00
        step(1'b0, 1'b1, 3'd4, 2'd1, 8'hFE, 8'h00, 1'b0, 1'b0);
        step(1'b0, 1'b1, 3'd7, 2'd2, 8'h00, 8'h00, 1'b0, 1'b0);
        step(1'b0, 1'b1, 3'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0);
        check("R3 wrap", pc, 8'h00);
        // R6 boundary offsets: FF keeps pc, 80 goes back 127
        step(1'b0, 1'b1, 3'd4, 2'd1, 8'h90, 8'h00, 1'b0, 1'b0);
        step(1'b0, 1'b1, 3'd4, 2'd0, 8'hFF, 8'h00, 1'b0, 1'b0);
        check("R6 offset FF", pc, 8'h90);
        step(1'b0, 1'b1, 3'd4, 2'd0, 8'h80, 8'h00, 1'b0, 1'b0);
        check("R6 offset 80", pc, 8'h11);
        step(1'b0, 1'b1, 3'd4, 2'd0, 8'h7F, 8'h00, 1'b0, 1'b0);
        check("R6 offset 7F", pc, 8'h91);
        // R2 hold while a jump is presented
        step(1'b0, 1'b0, 3'd4, 2'd2, 8'h00, 8'hAA, 1'b0, 1'b0);
        check("R2 hold", pc, 8'h91);
        // sweep of opcodes, modes, flags and operands
        for (int op = 0; op < 8; op++)
            for (int md = 0; md < 4; md++)
                for (int f = 0; f < 4; f++)
                    for (int k = 0; k < 18; k++) begin
                        logic [7:0] v;
                        v = (k == 16) ? 8'h80 : (k == 17) ? 8'h7F : 8'(k * 17);
                        step(1'b0, (k % 7) != 3, 3'(op), 2'(md), v,
                             v ^ 8'h5A ^ 8'(f), f[0], f[1]);
                    end
        // R1 reset mid-run with enable low
        step(1'b1, 1'b0, 3'd4, 2'd1, 8'h44, 8'h00, 1'b0, 1'b0);
        check("R1 mid-run", pc, 8'h00);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule